// File: doc/BRIEF.md
# Cycle-Indexed Event Timing Wheel

This block holds event identifiers until a chosen number of cycles has passed and then releases them. It has a fixed ring of slots. A request carries a delay and an identifier. The identifier goes into the slot found by adding the delay to the wheel's reference position, modulo the ring size. The chip's global cycle count arrives on `time_now`. That count is the sum of every kind of bus and internal cycle since reset, so it may advance by more than one per clock.

When events are waiting and the low bits of `time_now` have moved past the reference position, the wheel sweeps every slot from the reference position up to the new position, inclusive, wrapping from the last slot to slot 0. It releases the stored identifiers one per clock on a valid/ID stream, and the reference position then takes the new value. While the wheel is empty, the reference position follows `time_now`, so the first event always counts its delay from the present. A zero delay cannot be held by the wheel; the surrounding logic must fire such an event itself.

Top module: `event_wheel`

## Requirements
- R1: After reset, `pending` is 0, `sched_ready` is 1, and `fire_valid` and `overflow` are 0.
- R2: A request accepted (`sched_valid` and `sched_ready` high at a clock edge) with `sched_delay` from 1 to NSLOTS-1 stores its ID in slot (reference + delay) mod NSLOTS. `pending` goes up by one.
- R3: A request with `sched_delay` equal to 0 is ignored. `pending` and `overflow` do not change, and the request never fires.
- R4: A request accepted while `pending` is 0 uses `time_now` mod NSLOTS as its reference, not any older reference.
- R5: When `pending` is nonzero and `time_now` mod NSLOTS differs from the reference, the wheel services slots from the reference to that position, inclusive, in increasing order. It wraps from NSLOTS-1 to 0, and the reference then becomes that position.
- R6: Each released event shows for one clock as `fire_valid`=1 with its `fire_id`. At most one event is released per clock, and `pending` drops by one for each.
- R7: Events that share a slot are released newest first.
- R8: A slot holds at most DEPTH (4) events. A request aimed at a full slot is dropped, `pending` is unchanged, and `overflow` is 1 for the one clock after that edge.
- R9: `sched_ready` is 0 while a sweep is due or in progress.
- R10: An event whose slot lies outside the swept range is not released and stays counted in `pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| time_now | input | TW | Global cycle count |
| sched_valid | input | 1 | Schedule request valid |
| sched_ready | output | 1 | Wheel can accept a request |
| sched_delay | input | log2(NSLOTS) | Delay in cycles, 1 to NSLOTS-1 |
| sched_id | input | IDW | Event identifier to schedule |
| fire_valid | output | 1 | A released event is on `fire_id` |
| fire_id | output | IDW | Identifier of the released event |
| pending | output | log2(NSLOTS*DEPTH+1) | Number of events held |
| overflow | output | 1 | Previous request was dropped because its slot was full |

## Verification
The bench makes the global count jump by several positions at once. A wheel that checked only the current slot would then leave events stranded. The sweep is also made to cross from the last slot back to slot 0; if the wraparound is wrong, events come out in the wrong order or never come out. One test leaves the wheel empty while time moves on and then schedules an event. If the reference is stale, that event fires on a partial sweep it should survive. Other tests fill one slot past its capacity, send a zero delay, and put several events in one slot. These catch a wheel that miscounts, keeps a zero-delay request, or releases same-slot events oldest first.

// File: rtl/event_wheel.sv
module event_wheel #(
  parameter int NSLOTS = 8,
  parameter int DEPTH  = 4,
  parameter int IDW    = 8,
  parameter int TW     = 16,
  localparam int SW = $clog2(NSLOTS),
  localparam int OW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(NSLOTS * DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  time_now,
  input  logic           sched_valid,
  output logic           sched_ready,
  input  logic [SW-1:0]  sched_delay,
  input  logic [IDW-1:0] sched_id,
  output logic           fire_valid,
  output logic [IDW-1:0] fire_id,
  output logic [CW-1:0]  pending,
  output logic           overflow
);

  logic [IDW-1:0] mem [NSLOTS][DEPTH];
  logic [OW-1:0]  occ [NSLOTS];
  logic [SW-1:0]  base, cur, stop;
  logic           busy;

  wire [SW-1:0] pos    = time_now[SW-1:0];
  wire [SW-1:0] origin = (pending == '0) ? pos : base;
  wire [SW-1:0] tgt    = origin + sched_delay;
  wire          full   = (occ[tgt] == OW'(DEPTH));
  wire          take   = sched_valid && sched_ready && (sched_delay != '0);
  wire          push   = take && !full;
  wire [OW-1:0] top    = occ[cur] - 1'b1;

  assign sched_ready = !busy && ((pending == '0) || (pos == base));
  assign fire_valid  = busy && (occ[cur] != '0);
  assign fire_id     = mem[cur][top[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[tgt][occ[tgt][AW-1:0]] <= sched_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base     <= '0;
      cur      <= '0;
      stop     <= '0;
      busy     <= 1'b0;
      pending  <= '0;
      overflow <= 1'b0;
      for (int s = 0; s < NSLOTS; s++) occ[s] <= '0;
    end else begin
      overflow <= take && full;
      if (busy) begin
        if (occ[cur] != '0) begin
          occ[cur] <= occ[cur] - 1'b1;
          pending  <= pending - 1'b1;
        end else if (cur == stop) begin
          busy <= 1'b0;
          base <= stop;
        end else begin
          cur <= cur + 1'b1;
        end
      end else begin
        if (pending == '0) begin
          base <= pos;
        end else if (pos != base) begin
          busy <= 1'b1;
          cur  <= base;
          stop <= pos;
        end
        if (push) begin
          occ[tgt] <= occ[tgt] + 1'b1;
          pending  <= pending + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/event_wheel_chk.sv
module event_wheel_chk #(
  parameter int SW  = 3,
  parameter int CW  = 6,
  parameter int CAP = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sched_valid,
  input logic          sched_ready,
  input logic [SW-1:0] sched_delay,
  input logic          fire_valid,
  input logic [CW-1:0] pending,
  input logic          overflow
);

  a_r6_fire_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid |-> pending != '0);

  a_r6_fire_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid |=> pending == CW'($past(pending) - 1'b1));

  a_r9_stall_while_firing: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid |-> !sched_ready);

  a_r3_zero_delay_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_valid && sched_ready && sched_delay == '0) |=> (pending == $past(pending)) && !overflow);

  a_r2_accept_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_valid && sched_ready && sched_delay != '0) |=> (pending == CW'($past(pending) + 1'b1)) || overflow);

  a_r8_overflow_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> pending == $past(pending));

  a_r8_capacity_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= CW'(CAP));

endmodule

bind event_wheel event_wheel_chk #(.SW(SW), .CW(CW), .CAP(NSLOTS * DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sched_valid(sched_valid), .sched_ready(sched_ready),
  .sched_delay(sched_delay), .fire_valid(fire_valid), .pending(pending), .overflow(overflow)
);

// File: tb/event_wheel_tb.sv
module event_wheel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] time_now = '0;
  logic        sched_valid = 1'b0;
  logic        sched_ready;
  logic [2:0]  sched_delay = '0;
  logic [7:0]  sched_id = '0;
  logic        fire_valid;
  logic [7:0]  fire_id;
  logic [5:0]  pending;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  logic [7:0] expq [$];

  always #2.5 clk = ~clk;

  event_wheel u_dut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .sched_valid(sched_valid), .sched_ready(sched_ready),
    .sched_delay(sched_delay), .sched_id(sched_id),
    .fire_valid(fire_valid), .fire_id(fire_id),
    .pending(pending), .overflow(overflow)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sched(input logic [2:0] d, input logic [7:0] id);
    @(negedge clk);
    while (!sched_ready) @(negedge clk);
    sched_valid = 1'b1;
    sched_delay = d;
    sched_id    = id;
    @(negedge clk);
    sched_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 200 && pending != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    check({tag, " pending drained"}, pending, 0);
    check({tag, " all expected fired"}, expq.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && fire_valid) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected fire actual=%0d expected=none", fire_id);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if (e != fire_id) begin
          fails++;
          $display("FAIL R7 fire order actual=%0d expected=%0d", fire_id, e);
        end
      end
    end
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pending", pending, 0);
    check("R1 ready", sched_ready, 1);
    check("R1 fire_valid", fire_valid, 0);
    check("R1 overflow", overflow, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R7: two events into slot 2, one into slot 5; zero delay dropped (R3)
    sched(3'd2, 8'h11);
    check("R2 count one", pending, 1);
    sched(3'd2, 8'h22);
    sched(3'd5, 8'h33);
    check("R2 count three", pending, 3);
    sched(3'd0, 8'h44);
    check("R3 zero delay count", pending, 3);
    check("R3 zero delay overflow", overflow, 0);
    expq.push_back(8'h22);
    expq.push_back(8'h11);
    expq.push_back(8'h33);
    time_now = 16'd6;
    #1;
    check("R9 ready low when sweep due", sched_ready, 0);
    drain("R5 jump sweep");

    // R5: sweep that wraps past the last slot
    time_now = 16'd14;
    @(negedge clk);
    sched(3'd3, 8'h55);
    sched(3'd7, 8'h66);
    check("R2 wrap schedule count", pending, 2);
    expq.push_back(8'h55);
    expq.push_back(8'h66);
    time_now = 16'd21;
    drain("R5 wrap sweep");

    // R4/R10: base reload after idle, partial sweep must not release
    time_now = 16'd27;
    @(negedge clk);
    sched(3'd4, 8'h77);
    time_now = 16'd28;
    repeat (8) @(negedge clk);
    check("R10 event kept outside range", pending, 1);
    check("R4 ready after partial sweep", sched_ready, 1);
    expq.push_back(8'h77);
    time_now = 16'd31;
    drain("R4 reload");

    // R8: fill one slot, fifth is dropped
    @(negedge clk);
    for (int k = 1; k <= 4; k++) begin
      sched(3'd1, 8'(k));
      check("R8 no overflow while room", overflow, 0);
    end
    sched(3'd1, 8'd5);
    check("R8 overflow flagged", overflow, 1);
    check("R8 count unchanged", pending, 4);
    @(negedge clk);
    check("R8 overflow one cycle", overflow, 0);
    for (int k = 4; k >= 1; k--) expq.push_back(8'(k));
    time_now = 16'd32;
    drain("R6 slot release");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule